// File: doc/BRIEF.md
# Half-Word Masked-Write GPIO Port

This block controls a port of 32 general-purpose pins through a small memory-mapped register bus. The output-data and direction state are each 32 bits wide. Each one is split across two consecutive bus words, one for pins 0 to 15 and one for pins 16 to 31. A write to either word carries up to 16 new pin values in its low half and a per-bit write-enable in its high half. Software can therefore set, clear or redirect a single pin in one bus write, with no read-modify-write sequence and no race against other software that owns other pins.

The pad side drives an output value and an output enable for every pin. The external pin levels pass through a two-flop synchroniser and can be read back as one 32-bit word. A fixed identifier word reports the block revision. Requests use a valid/ready channel. One request is accepted at a time, and each accepted request, read or write, produces exactly one response on a valid/ready response channel. A new request is refused while a response waits for `rsp_ready`. This is how back-pressure from the response side reaches the request side.

Top module: `gpio_hw_port`

## Requirements
- R1: After reset all output-data and direction bits are 0: `pad_out` and `pad_oe` are all zero, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write to byte address 0x00 updates pin n (n in 0..15) to `req_wdata[n]` only when `req_wdata[n+16]` is 1; every other stored data bit keeps its value.
- R3: A write to byte address 0x04 applies the same masking to pins 16..31, where `req_wdata[k]` with enable `req_wdata[k+16]` targets pin k+16. The direction state uses address 0x08 for pins 0..15 and 0x0C for pins 16..31, with the same masking.
- R4: A read of 0x00, 0x04, 0x08 or 0x0C returns the 16 stored bits of that half in `rsp_rdata[15:0]`, with `rsp_rdata[31:16]` zero.
- R5: `pad_oe[n]` equals direction bit n (1 = drive, 0 = input), and `pad_out[n]` equals data bit n.
- R6: A read of 0x70 returns `pin_in` through two flops. A read accepted on the second rising edge after a pin change still returns the old level. A read accepted on the third rising edge or later returns the new level.
- R7: A read of 0x78 returns the constant `VERSION`, laid out as major in bits [31:24], minor in [23:16] and revision in [15:0]. The default is 0x01020037.
- R8: Writes to 0x70, 0x78 or any unmapped address leave `pad_out` and `pad_oe` unchanged. Reads of unmapped addresses return 0.
- R9: `req_ready` is low while `rsp_valid` is high. A response holds `rsp_valid` and `rsp_rdata` stable until `rsp_ready` is 1. A write response carries data 0. The response appears on the rising edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word: enables in [31:16], values in [15:0] |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pin_in | input | 32 | External pin levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The assertions assume that `rst_n` is low for at least one edge at the start of the run. They also assume that the request fields are known and stable whenever `req_valid` is high, so that the captured address and mask decide the checked outcome. The bench changes stimulus only on falling edges and holds each request for exactly the accepting edge. It always drains a response before it issues the next request, except in the back-pressure scenario, where it deliberately withholds `rsp_ready`.

// File: rtl/gpio_hw_pkg.sv
package gpio_hw_pkg;
  localparam logic [15:0] OFF_DATA_LO = 16'h0000;
  localparam logic [15:0] OFF_DATA_HI = 16'h0004;
  localparam logic [15:0] OFF_DIR_LO  = 16'h0008;
  localparam logic [15:0] OFF_DIR_HI  = 16'h000C;
  localparam logic [15:0] OFF_EXT     = 16'h0070;
  localparam logic [15:0] OFF_VER     = 16'h0078;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA_LO, SEL_DATA_HI, SEL_DIR_LO, SEL_DIR_HI, SEL_EXT, SEL_VER
  } sel_e;

  function automatic sel_e decode_addr(input logic [15:0] a);
    case (a)
      OFF_DATA_LO: return SEL_DATA_LO;
      OFF_DATA_HI: return SEL_DATA_HI;
      OFF_DIR_LO:  return SEL_DIR_LO;
      OFF_DIR_HI:  return SEL_DIR_HI;
      OFF_EXT:     return SEL_EXT;
      OFF_VER:     return SEL_VER;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_hw_halfreg.sv
module gpio_hw_halfreg #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]     q
);
  logic [HALF_W-1:0] mask, vals;
  assign vals = wdata[HALF_W-1:0];
  assign mask = wdata[2*HALF_W-1:HALF_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= (q & ~mask) | (vals & mask);
  end
endmodule

// File: rtl/gpio_hw_sync.sv
module gpio_hw_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_hw_bus.sv
module gpio_hw_bus
  import gpio_hw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16,
  parameter logic [2*HALF_W-1:0] VERSION = 32'h0102_0037
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                rsp_ready,
  output logic                rsp_valid,
  output logic [2*HALF_W-1:0] rsp_rdata,
  input  logic [2*HALF_W-1:0] data_q,
  input  logic [2*HALF_W-1:0] dir_q,
  input  logic [2*HALF_W-1:0] ext_q,
  output logic [3:0]          wr_stb
);
  localparam int W = 2 * HALF_W;

  logic [15:0] addr_x;
  sel_e        sel;
  logic        accept, wr;
  logic [W-1:0] rd_mux;

  assign addr_x    = 16'(req_addr);
  assign sel       = decode_addr(addr_x);
  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write;

  // strobe order: data lo, data hi, dir lo, dir hi
  assign wr_stb[0] = wr && (sel == SEL_DATA_LO);
  assign wr_stb[1] = wr && (sel == SEL_DATA_HI);
  assign wr_stb[2] = wr && (sel == SEL_DIR_LO);
  assign wr_stb[3] = wr && (sel == SEL_DIR_HI);

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA_LO: rd_mux[HALF_W-1:0] = data_q[HALF_W-1:0];
      SEL_DATA_HI: rd_mux[HALF_W-1:0] = data_q[W-1:HALF_W];
      SEL_DIR_LO:  rd_mux[HALF_W-1:0] = dir_q[HALF_W-1:0];
      SEL_DIR_HI:  rd_mux[HALF_W-1:0] = dir_q[W-1:HALF_W];
      SEL_EXT:     rd_mux = ext_q;
      SEL_VER:     rd_mux = VERSION;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_hw_port.sv
module gpio_hw_port #(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [2*HALF_W-1:0] VERSION = 32'h0102_0037
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*HALF_W-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*HALF_W-1:0] rsp_rdata,
  input  logic [2*HALF_W-1:0] pin_in,
  output logic [2*HALF_W-1:0] pad_out,
  output logic [2*HALF_W-1:0] pad_oe
);
  localparam int W = 2 * HALF_W;

  logic [3:0]   wr_stb;
  logic [W-1:0] data_q, dir_q, ext_q;

  gpio_hw_bus #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .VERSION(VERSION)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .data_q(data_q), .dir_q(dir_q), .ext_q(ext_q),
    .wr_stb(wr_stb)
  );

  // index 0/1: data halves, 2/3: direction halves
  for (genvar r = 0; r < 2; r++) begin : g_reg
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0] q;
      gpio_hw_halfreg #(.HALF_W(HALF_W)) u_half (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_stb[2*r+h]),
        .wdata(req_wdata), .q(q)
      );
      if (r == 0) begin : g_data
        assign data_q[h*HALF_W +: HALF_W] = q;
      end else begin : g_dir
        assign dir_q[h*HALF_W +: HALF_W] = q;
      end
    end
  end

  gpio_hw_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(ext_q)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_hw_port_chk.sv
module gpio_hw_port_chk
  import gpio_hw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [2*HALF_W-1:0] req_wdata,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [2*HALF_W-1:0] rsp_rdata,
  input logic [2*HALF_W-1:0] pad_out,
  input logic [2*HALF_W-1:0] pad_oe
);
  localparam int W = 2 * HALF_W;
  sel_e sel;
  logic acc, acc_rd, acc_wr, mask_zero;
  assign sel       = decode_addr(16'(req_addr));
  assign acc       = req_valid && req_ready;
  assign acc_rd    = acc && !req_write;
  assign acc_wr    = acc && req_write;
  assign mask_zero = (req_wdata[W-1:HALF_W] == '0);

  // R9
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R9
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R9
  p_wr_rsp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (rsp_valid && rsp_rdata == '0));
  // R2
  p_data_lo_nomask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && sel == SEL_DATA_LO && mask_zero) |=> $stable(pad_out));
  // R3
  p_dir_hi_nomask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && sel == SEL_DIR_HI && mask_zero) |=> $stable(pad_oe));
  // R8
  p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && (sel == SEL_EXT || sel == SEL_VER || sel == SEL_NONE))
      |=> ($stable(pad_out) && $stable(pad_oe)));
  // R8
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && sel == SEL_NONE) |=> (rsp_rdata == '0));
  // R4
  p_half_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (sel == SEL_DATA_LO || sel == SEL_DATA_HI ||
                sel == SEL_DIR_LO  || sel == SEL_DIR_HI))
      |=> (rsp_rdata[W-1:HALF_W] == '0));
endmodule

bind gpio_hw_port gpio_hw_port_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/gpio_hw_port_tb.sv
module gpio_hw_port_tb;
  localparam logic [31:0] VER = 32'h0102_0037;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, pin_in = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata, pad_out, pad_oe;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_data = '0, m_dir = '0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_hw_port u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mupd(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  // one transfer; hold = extra cycles with rsp_ready low
  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                      input int hold, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < hold; i++) begin
      logic [31:0] snap;
      snap = rsp_rdata;
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_rdata == snap, "R9 hold", rsp_rdata, snap);
    end
    rd = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wr_data(input bit hi, input logic [31:0] w);
    logic [31:0] d;
    xfer(1, hi ? 8'h04 : 8'h00, w, 0, d);
    if (hi) m_data[31:16] = mupd(m_data[31:16], w); else m_data[15:0] = mupd(m_data[15:0], w);
    chk(d == 0, "R9 write rsp", d, 0);
  endtask

  task automatic wr_dir(input bit hi, input logic [31:0] w);
    logic [31:0] d;
    xfer(1, hi ? 8'h0C : 8'h08, w, 0, d);
    if (hi) m_dir[31:16] = mupd(m_dir[31:16], w); else m_dir[15:0] = mupd(m_dir[15:0], w);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(pad_out == 0 && pad_oe == 0, "R1 pads", pad_out | pad_oe, 0);
    chk(!rsp_valid && req_ready, "R1 handshake", {rsp_valid, req_ready}, 1);
    xfer(0, 8'h0C, 0, 0, d);
    chk(d == 0, "R1 dir hi read", d, 0);
  endtask

  task automatic t_low_mask;
    wr_data(0, 32'hFFFF_A5A5);
    chk(pad_out == m_data, "R2 full mask", pad_out, m_data);
    wr_data(0, 32'h0001_0000);
    chk(pad_out == 32'h0000_A5A4, "R2 single bit", pad_out, 32'h0000_A5A4);
    wr_data(0, 32'h0000_FFFF);
    chk(pad_out == 32'h0000_A5A4, "R2 zero mask", pad_out, 32'h0000_A5A4);
  endtask

  task automatic t_high_mask;
    wr_data(1, 32'h00F0_00F0);
    chk(pad_out == 32'h00F0_A5A4, "R3 data hi", pad_out, 32'h00F0_A5A4);
    wr_data(1, 32'h8010_0000);
    chk(pad_out == m_data, "R3 data hi clr", pad_out, m_data);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    xfer(0, 8'h00, 0, 0, d);
    chk(d == {16'h0, m_data[15:0]}, "R4 data lo", d, {16'h0, m_data[15:0]});
    xfer(0, 8'h04, 0, 0, d);
    chk(d == {16'h0, m_data[31:16]}, "R4 data hi", d, {16'h0, m_data[31:16]});
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr_dir(0, 32'h0003_0001);
    wr_dir(1, 32'h8000_8000);
    chk(pad_oe == 32'h8000_0001, "R5 pad_oe", pad_oe, 32'h8000_0001);
    chk(pad_out == m_data, "R5 pad_out kept", pad_out, m_data);
    xfer(0, 8'h08, 0, 0, d);
    chk(d == 32'h0000_0001, "R3 dir lo read", d, 32'h0000_0001);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    xfer(0, 8'h70, 0, 0, d);
    chk(d == 32'hDEAD_BEEF, "R6 settled", d, 32'hDEAD_BEEF);
    pin_in = 32'h1234_5678;   // at a falling edge; read accepted on 2nd rising edge
    @(posedge clk);
    xfer(0, 8'h70, 0, 0, d);
    chk(d == 32'hDEAD_BEEF, "R6 too early", d, 32'hDEAD_BEEF);
    xfer(0, 8'h70, 0, 0, d);
    chk(d == 32'h1234_5678, "R6 new level", d, 32'h1234_5678);
  endtask

  task automatic t_version;
    logic [31:0] d;
    xfer(0, 8'h78, 0, 0, d);
    chk(d == VER, "R7 version", d, VER);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    xfer(1, 8'h70, 32'hFFFF_FFFF, 0, d);
    xfer(1, 8'h78, 32'hFFFF_FFFF, 0, d);
    xfer(1, 8'h10, 32'hFFFF_FFFF, 0, d);
    xfer(1, 8'h7C, 32'hFFFF_FFFF, 0, d);
    chk(pad_out == m_data && pad_oe == m_dir, "R8 ro writes", pad_out ^ pad_oe, m_data ^ m_dir);
    xfer(0, 8'h44, 0, 0, d);
    chk(d == 0, "R8 unmapped read", d, 0);
    xfer(0, 8'h78, 0, 0, d);
    chk(d == VER, "R8 version kept", d, VER);
  endtask

  task automatic t_backpressure;
    logic [31:0] d;
    xfer(0, 8'h78, 0, 3, d);
    chk(d == VER, "R9 held data", d, VER);
    chk(!rsp_valid && req_ready, "R9 drained", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_mask();
    t_high_mask();
    t_readback();
    t_dir();
    t_ext();
    t_version();
    t_ignored();
    t_backpressure();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule